// File: doc/BRIEF.md
# Indirect Flash Read Transfer Controller

This block moves a bulk read from a serial flash into a small local word buffer, from which software drains the data. Software writes the flash start address and the number of bytes to fetch, then sets the start bit in the control register. The controller then asks a serial engine for one 32-bit word at a time. It steps the address by four for each word and tells the engine how many bytes of that word are still wanted. Each returned word goes into the buffer. Software polls a level register that reports the buffer fill in words, and pulls words out through a ready/valid drain port.

The transfer counts as complete once every requested byte has come back from the engine and been drained from the buffer. At that point the in-progress bit drops and the done bit rises. The done bit stays set until software writes a one to it. A cancel stops further engine requests, empties the buffer, drops in-progress and leaves done clear. The read opcode, data-lane type, dummy-cycle count and address width are held in registers and passed straight through to the serial engine.

Top module: `flash_bulk_reader`

## Requirements
- R1: After reset the control register (word offset 0) and the level register (word offset 3) read zero, and neither `eng_req_valid` nor `drain_valid` is asserted.
- R2: A write to the control register with bit 0 set, while idle, sets the in-progress bit (bit 2). It then issues engine requests starting at the address register (offset 2), stepping by 4 per word. Each request carries `min(4, bytes left)` in `eng_req_nbytes`. A pending request holds its address until accepted.
- R3: The buffer never holds more than DEPTH words. While it is full, no engine request is issued.
- R4: When the byte count (offset 1) is not a multiple of 4, the last word carries only the remaining low bytes, and its unused high bytes read as zero.
- R5: The level register reports the buffer fill in 32-bit words in bits 15:0, with bits 31:16 zero.
- R6: When all requested bytes have been received and drained, in-progress clears and the done bit (bit 5) sets in the same cycle. Done and in-progress are never set together.
- R7: Writing the control register with bit 5 set clears done. A control write with bit 5 clear leaves done unchanged.
- R8: A control write with bit 1 set, while in progress, clears in-progress, leaves done clear, and empties the buffer (level 0). No further engine requests are issued, and a response still in flight is discarded.
- R9: The read-instruction register (offset 4) drives `eng_opcode` from bits 7:0, `eng_lanes` from bits 17:16 and `eng_dummy` from bits 28:24. The size register (offset 5) drives `eng_addr_len_m1` from bits 3:0. Both registers read back what was written to those fields.
- R10: A start write while in progress is ignored. The running transfer keeps its original address and length, even when those registers are rewritten.
- R11: Words leave the drain port in flash address order.
- R12: A start with a byte count of zero issues no engine request and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset, used for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| eng_req_valid | output | 1 | Word request to the serial engine |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_addr | output | FADDR_W | Flash byte address of the requested word |
| eng_req_nbytes | output | 3 | Bytes wanted in this word (1 to 4) |
| eng_opcode | output | 8 | Read opcode |
| eng_lanes | output | 2 | Data-lane type |
| eng_dummy | output | 5 | Dummy clock count |
| eng_addr_len_m1 | output | 4 | Flash address bytes minus one |
| eng_rsp_valid | input | 1 | Engine returns the requested word |
| eng_rsp_data | input | 32 | Returned word, byte 0 in bits 7:0 |
| drain_valid | output | 1 | Buffer holds a word |
| drain_ready | input | 1 | Software takes the word |
| drain_data | output | 32 | Oldest buffered word |

## Verification
On every cycle, the bound assertions check the following:
- the buffer never exceeds its depth, and no request is issued while it is full;
- done and in-progress are never set together;
- a cancel empties the buffer and leaves done clear;
- a done-clear write takes effect;
- a stalled request keeps its address.

Other behaviours only show up in the bench's scenarios, where a scoreboard compares every engine request and every drained word against expected values:
- address order and stepping;
- masking of the partial last word;
- a start while busy being ignored;
- a stale response after a cancel being discarded;
- a zero-length transfer ending without any request.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   localparam int WORD_BYTES = 4;
   localparam int LVL_FIELD_W = 16;

   // register word offsets
   localparam int OFS_CTRL  = 0;
   localparam int OFS_LEN   = 1;
   localparam int OFS_ADDR  = 2;
   localparam int OFS_LEVEL = 3;
   localparam int OFS_INSTR = 4;
   localparam int OFS_SIZE  = 5;

   // control bit positions
   localparam int CB_START  = 0;
   localparam int CB_CANCEL = 1;
   localparam int CB_BUSY   = 2;
   localparam int CB_DONE   = 5;

   typedef struct packed {
      logic [7:0] opcode;
      logic [1:0] lanes;
      logic [4:0] dummy;
      logic [3:0] addr_m1;
   } fbr_cfg_t;
endpackage

// File: rtl/fbr_regs.sv
module fbr_regs
   import fbr_pkg::*;
#(
   parameter int REG_AW  = 3,
   parameter int LEN_W   = 20,
   parameter int FADDR_W = 32,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_AW-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic               busy,
   input  logic               done,
   input  logic [CNT_W-1:0]   level,
   output logic               start_p,
   output logic               cancel_p,
   output logic               done_clr_p,
   output logic [LEN_W-1:0]   len_q,
   output logic [FADDR_W-1:0] addr_q,
   output fbr_cfg_t           cfg_q
);
   localparam int LVL_PAD = 32 - LVL_FIELD_W;

   logic sel_ctrl, sel_len, sel_addr, sel_instr, sel_size;

   assign sel_ctrl  = wr_en && (addr == REG_AW'(OFS_CTRL));
   assign sel_len   = wr_en && (addr == REG_AW'(OFS_LEN));
   assign sel_addr  = wr_en && (addr == REG_AW'(OFS_ADDR));
   assign sel_instr = wr_en && (addr == REG_AW'(OFS_INSTR));
   assign sel_size  = wr_en && (addr == REG_AW'(OFS_SIZE));

   assign start_p    = sel_ctrl && wdata[CB_START];
   assign cancel_p   = sel_ctrl && wdata[CB_CANCEL];
   assign done_clr_p = sel_ctrl && wdata[CB_DONE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         addr_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (sel_len)   len_q  <= wdata[LEN_W-1:0];
         if (sel_addr)  addr_q <= wdata[FADDR_W-1:0];
         if (sel_instr) begin
            cfg_q.opcode <= wdata[7:0];
            cfg_q.lanes  <= wdata[17:16];
            cfg_q.dummy  <= wdata[28:24];
         end
         if (sel_size)  cfg_q.addr_m1 <= wdata[3:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_AW'(OFS_CTRL): begin
            rdata[CB_BUSY] = busy;
            rdata[CB_DONE] = done;
         end
         REG_AW'(OFS_LEN):   rdata = 32'(len_q);
         REG_AW'(OFS_ADDR):  rdata = 32'(addr_q);
         REG_AW'(OFS_LEVEL): rdata = {{LVL_PAD{1'b0}}, LVL_FIELD_W'(level)};
         REG_AW'(OFS_INSTR): rdata = {3'b0, cfg_q.dummy, 6'b0, cfg_q.lanes, 8'b0, cfg_q.opcode};
         REG_AW'(OFS_SIZE):  rdata = {28'b0, cfg_q.addr_m1};
         default:            rdata = '0;
      endcase
   end
endmodule

// File: rtl/fbr_buffer.sv
module fbr_buffer #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_ready,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              pop;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fbr_buffer: DEPTH must be a power of two");
      end
   endgenerate

   assign pop_valid = (count != '0);
   assign pop_data  = mem[rd_ptr];
   assign pop       = pop_valid && pop_ready;

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/fbr_sequencer.sv
module fbr_sequencer
   import fbr_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int LEN_W   = 20,
   parameter int FADDR_W = 32,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_p,
   input  logic               cancel_p,
   input  logic               done_clr_p,
   input  logic [LEN_W-1:0]   len_q,
   input  logic [FADDR_W-1:0] addr_q,
   input  logic [CNT_W-1:0]   level,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [FADDR_W-1:0] req_addr,
   output logic [2:0]         req_nbytes,
   input  logic               rsp_valid,
   output logic               push,
   output logic               flush,
   output logic [2:0]         last_nbytes,
   output logic               busy,
   output logic               done
);
   logic [LEN_W-1:0]   bytes_left;
   logic [FADDR_W-1:0] cur_addr;
   logic               pending, stale;
   logic               fire, take_start, take_cancel, finish, pending_n;

   assign take_cancel = cancel_p && busy;
   assign take_start  = start_p && !cancel_p && !busy;

   assign req_valid  = busy && (bytes_left != '0) && !pending && (level < CNT_W'(DEPTH));
   assign req_addr   = cur_addr;
   assign req_nbytes = (bytes_left >= LEN_W'(WORD_BYTES)) ? 3'(WORD_BYTES) : bytes_left[2:0];
   assign fire       = req_valid && req_ready;

   assign push   = rsp_valid && pending && !stale;
   assign flush  = take_cancel;
   assign finish = busy && (bytes_left == '0) && !pending && (level == '0) && !take_cancel;

   assign pending_n = (pending && !rsp_valid) || fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         done        <= 1'b0;
         bytes_left  <= '0;
         cur_addr    <= '0;
         pending     <= 1'b0;
         stale       <= 1'b0;
         last_nbytes <= '0;
      end else begin
         pending <= pending_n;
         if (rsp_valid) stale <= 1'b0;
         if (take_cancel && pending_n) stale <= 1'b1;

         if (take_start) begin
            busy       <= 1'b1;
            done       <= 1'b0;
            bytes_left <= len_q;
            cur_addr   <= addr_q;
         end else if (take_cancel) begin
            busy       <= 1'b0;
            bytes_left <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            if (done_clr_p) done <= 1'b0;
            if (fire) begin
               cur_addr    <= cur_addr + FADDR_W'(WORD_BYTES);
               bytes_left  <= bytes_left - LEN_W'(req_nbytes);
               last_nbytes <= req_nbytes;
            end
         end
      end
   end
endmodule

// File: rtl/flash_bulk_reader.sv
module flash_bulk_reader
   import fbr_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int LEN_W   = 20,
   parameter int FADDR_W = 32,
   parameter int REG_AW  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               eng_req_valid,
   input  logic               eng_req_ready,
   output logic [FADDR_W-1:0] eng_req_addr,
   output logic [2:0]         eng_req_nbytes,
   output logic [7:0]         eng_opcode,
   output logic [1:0]         eng_lanes,
   output logic [4:0]         eng_dummy,
   output logic [3:0]         eng_addr_len_m1,
   input  logic               eng_rsp_valid,
   input  logic [31:0]        eng_rsp_data,
   output logic               drain_valid,
   input  logic               drain_ready,
   output logic [31:0]        drain_data
);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int DATA_W = 8 * WORD_BYTES;

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("flash_bulk_reader: DEPTH must be at least 2");
      end
      if (CNT_W > LVL_FIELD_W) begin : g_chk_lvl
         $error("flash_bulk_reader: level does not fit the 16-bit field");
      end
      if (LEN_W < 3 || LEN_W > 32 || FADDR_W > 32) begin : g_chk_w
         $error("flash_bulk_reader: LEN_W or FADDR_W out of range");
      end
      if (REG_AW < 3) begin : g_chk_aw
         $error("flash_bulk_reader: REG_AW must reach six registers");
      end
   endgenerate

   logic               start_p, cancel_p, done_clr_p;
   logic [LEN_W-1:0]   len_q;
   logic [FADDR_W-1:0] addr_q;
   fbr_cfg_t           cfg_q;
   logic               seq_busy, seq_done, push, flush;
   logic [2:0]         last_nbytes;
   logic [CNT_W-1:0]   fill_cnt;
   logic [DATA_W-1:0]  push_data;

   fbr_regs #(.REG_AW(REG_AW), .LEN_W(LEN_W), .FADDR_W(FADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(seq_busy), .done(seq_done), .level(fill_cnt),
      .start_p(start_p), .cancel_p(cancel_p), .done_clr_p(done_clr_p),
      .len_q(len_q), .addr_q(addr_q), .cfg_q(cfg_q)
   );

   fbr_sequencer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .FADDR_W(FADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .cancel_p(cancel_p),
      .done_clr_p(done_clr_p), .len_q(len_q), .addr_q(addr_q), .level(fill_cnt),
      .req_valid(eng_req_valid), .req_ready(eng_req_ready), .req_addr(eng_req_addr),
      .req_nbytes(eng_req_nbytes), .rsp_valid(eng_rsp_valid), .push(push), .flush(flush),
      .last_nbytes(last_nbytes), .busy(seq_busy), .done(seq_done)
   );

   // byte lanes beyond the requested count of the last word are zeroed
   generate
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
         assign push_data[8*b +: 8] = (3'(b) < last_nbytes) ? eng_rsp_data[8*b +: 8] : 8'h00;
      end
   endgenerate

   fbr_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_data),
      .pop_ready(drain_ready), .pop_valid(drain_valid), .pop_data(drain_data),
      .count(fill_cnt)
   );

   assign eng_opcode      = cfg_q.opcode;
   assign eng_lanes       = cfg_q.lanes;
   assign eng_dummy       = cfg_q.dummy;
   assign eng_addr_len_m1 = cfg_q.addr_m1;
endmodule

// File: rtl/fbr_checks.sv
module fbr_checks #(
   parameter int DEPTH   = 8,
   parameter int CNT_W   = 4,
   parameter int FADDR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctrl_wr,
   input logic               w_start,
   input logic               w_cancel,
   input logic               w_doneclr,
   input logic               busy,
   input logic               done,
   input logic [CNT_W-1:0]   level,
   input logic               req_valid,
   input logic               req_ready,
   input logic [FADDR_W-1:0] req_addr
);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   a_r3_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (level == CNT_W'(DEPTH)) |-> !req_valid);

   a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r8_cancel_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && w_cancel && busy) |=> (level == '0 && !busy && !done));

   a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && w_doneclr && !w_start && !busy) |=> !done);

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !(ctrl_wr && w_cancel)) |=> (req_valid && $stable(req_addr)));
endmodule

bind flash_bulk_reader fbr_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FADDR_W(FADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ctrl_wr(reg_wr_en && (reg_addr == REG_AW'(fbr_pkg::OFS_CTRL))),
   .w_start(reg_wdata[fbr_pkg::CB_START]),
   .w_cancel(reg_wdata[fbr_pkg::CB_CANCEL]),
   .w_doneclr(reg_wdata[fbr_pkg::CB_DONE]),
   .busy(seq_busy), .done(seq_done), .level(fill_cnt),
   .req_valid(eng_req_valid), .req_ready(eng_req_ready), .req_addr(eng_req_addr)
);

// File: tb/flash_bulk_reader_test.sv
`timescale 1ns/1ps
module flash_bulk_reader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_req_valid;
   logic        eng_req_ready = 1'b1;
   logic [31:0] eng_req_addr;
   logic [2:0]  eng_req_nbytes;
   logic [7:0]  eng_opcode;
   logic [1:0]  eng_lanes;
   logic [4:0]  eng_dummy;
   logic [3:0]  eng_addr_len_m1;
   logic        eng_rsp_valid = 1'b0;
   logic [31:0] eng_rsp_data = '0;
   logic        drain_valid;
   logic        drain_ready = 1'b0;
   logic [31:0] drain_data;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   logic [34:0] req_q[$];
   int   eng_lat = 1;
   int   pend_cnt = 0;
   logic [31:0] pend_addr;
   logic drain_en = 1'b0;
   logic throttle = 1'b0;
   int   cyc = 0;
   logic finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   flash_bulk_reader uut (.*);

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h1357};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // driver: queue the expected requests and words of one transfer
   task automatic expect_xfer(input logic [31:0] addr, input int len);
      for (int off = 0; off < len; off += 4) begin
         int nb = (len - off >= 4) ? 4 : len - off;
         logic [31:0] m = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
         exp_q.push_back(pat(addr + off) & m);
         req_q.push_back({3'(nb), addr + 32'(off)});
      end
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] v;
      int n = 0;
      do begin rd(3'd0, v); n++; end while (!v[5] && n < 3000);
      check(tag, v, 32'h20);
   endtask

   // engine model: checks each accepted request, answers after eng_lat cycles
   initial begin
      forever begin
         @(negedge clk);
         eng_rsp_valid = 1'b0;
         if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               eng_rsp_valid = 1'b1;
               eng_rsp_data  = pat(pend_addr);
            end
         end else if (eng_req_valid && eng_req_ready) begin
            logic [34:0] e;
            if (req_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R2/R8 unexpected request actual=%h expected=none", eng_req_addr);
            end else begin
               e = req_q.pop_front();
               check("R2 request address", eng_req_addr, e[31:0]);
               check("R2 request byte count", 32'(eng_req_nbytes), 32'(e[34:32]));
            end
            pend_addr = eng_req_addr;
            pend_cnt  = eng_lat;
         end
      end
   end

   // monitor: drains words and compares them with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         drain_ready = drain_en && !(throttle && (cyc % 3 == 0));
         if (drain_ready && drain_valid) begin
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R11 unexpected word actual=%h expected=none", drain_data);
            end else begin
               check("R11/R4 drained word", drain_data, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, v); check("R1 ctrl after reset", v, 32'h0);
      rd(3'd3, v); check("R1 level after reset", v, 32'h0);
      check("R1 no request after reset", 32'(eng_req_valid), 32'h0);
      check("R1 no drain after reset", 32'(drain_valid), 32'h0);

      // R9 instruction and size fields
      wr(3'd4, 32'h0802_006B);
      wr(3'd5, 32'h0000_0003);
      @(negedge clk);
      check("R9 opcode", 32'(eng_opcode), 32'h6B);
      check("R9 lanes", 32'(eng_lanes), 32'h2);
      check("R9 dummy", 32'(eng_dummy), 32'h8);
      check("R9 address length", 32'(eng_addr_len_m1), 32'h3);
      rd(3'd4, v); check("R9 instruction readback", v, 32'h0802_006B);

      // R3 R5 full buffer stall, R10 start while busy ignored
      drain_en = 1'b0; eng_lat = 1;
      wr(3'd2, 32'h0000_1000);
      wr(3'd1, 32'd40);
      expect_xfer(32'h0000_1000, 40);
      wr(3'd0, 32'h1);
      rd(3'd0, v); check("R2 in-progress set", v, 32'h4);
      wr(3'd2, 32'h0000_9000);
      wr(3'd1, 32'd8);
      wr(3'd0, 32'h1);
      repeat (60) @(negedge clk);
      rd(3'd3, v); check("R5/R3 level at full", v, 32'd8);
      check("R3 no request when full", 32'(eng_req_valid), 32'h0);
      drain_en = 1'b1;
      wait_done("R6 done after full drain");
      check("R10/R11 scoreboard empty", 32'(exp_q.size() + req_q.size()), 32'h0);

      // R7 write-one-to-clear
      wr(3'd0, 32'h0);
      rd(3'd0, v); check("R7 done kept on zero write", v, 32'h20);
      wr(3'd0, 32'h20);
      rd(3'd0, v); check("R7 done cleared", v, 32'h0);

      // R4 partial final words, throttled drain
      eng_lat = 3; throttle = 1'b1;
      wr(3'd2, 32'h0000_2002);
      wr(3'd1, 32'd7);
      expect_xfer(32'h0000_2002, 7);
      wr(3'd0, 32'h1);
      wait_done("R4 done after 7 bytes");
      eng_lat = 1;
      wr(3'd2, 32'h0000_2100);
      wr(3'd1, 32'd13);
      expect_xfer(32'h0000_2100, 13);
      wr(3'd0, 32'h21);
      wait_done("R4 done after 13 bytes");
      throttle = 1'b0;

      // R12 zero length
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h1);
      repeat (3) @(negedge clk);
      rd(3'd0, v); check("R12 done on zero length", v, 32'h20);
      wr(3'd0, 32'h20);

      // R8 cancel with a response in flight
      drain_en = 1'b0; eng_lat = 8;
      wr(3'd2, 32'h0000_3000);
      wr(3'd1, 32'd64);
      expect_xfer(32'h0000_3000, 64);
      wr(3'd0, 32'h1);
      begin
         int n = 0;
         do begin rd(3'd3, v); n++; end while (!(v >= 3 && pend_cnt > 2) && n < 2000);
      end
      wr(3'd0, 32'h2);
      exp_q.delete();
      req_q.delete();
      rd(3'd0, v); check("R8 in-progress cleared, done clear", v, 32'h0);
      rd(3'd3, v); check("R8 buffer flushed", v, 32'h0);
      repeat (30) @(negedge clk);
      rd(3'd3, v); check("R8 stale response dropped", v, 32'h0);
      check("R8 no drain after cancel", 32'(drain_valid), 32'h0);
      rd(3'd0, v); check("R8 done stays clear", v, 32'h0);

      // R2 R11 fresh transfer after cancel
      eng_lat = 2; drain_en = 1'b1;
      wr(3'd2, 32'h0000_4000);
      wr(3'd1, 32'd20);
      expect_xfer(32'h0000_4000, 20);
      wr(3'd0, 32'h1);
      wait_done("R6 done after restart");
      check("R11 scoreboard empty at end", 32'(exp_q.size() + req_q.size()), 32'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule